// File: doc/BRIEF.md
# Dual-Format Pixel Byte Serializer

This block sits between a pixel source and a byte-wide SPI transmitter that feeds a display panel controller. It accepts one 24-bit RGB pixel at a time on a valid/ready handshake and emits the bytes the panel expects. Each byte goes out on a valid/ready byte interface with the data/command line held at the data level.

A format input picks one of two packings. The first is a 16-bit word, sent as two bytes. The second is an 18-bit form, sent as three bytes. Each of its bytes carries one channel, left-aligned, with the low two bits cleared. Only truncation is done: no rounding and no colour conversion.

A pixel counter tracks position within a frame. The frame length and the format are captured when the first pixel of a frame is accepted. A one-cycle end-of-frame pulse follows the last byte of the frame's final pixel.

Top module: `pxser_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `spi_valid` and `frame_end` are 0 and `pix_ready` is 1.
- R2: With `fmt_sel` = 0 (panel format code 0x55), each accepted pixel produces exactly 2 bytes on `spi_byte`.
- R3: In the 16-bit format, the packed word is `{r[7:3], g[7:2], b[7:3]}` (red in bits 15:11, green in 10:5, blue in 4:0). Its bits 15:8 are sent first and bits 7:0 second.
- R4: With `fmt_sel` = 1 (panel format code 0x66), each accepted pixel produces exactly 3 bytes, in the order red, green, blue.
- R5: In the 18-bit format, each channel byte equals `{c[7:2], 2'b00}` for its 8-bit channel value c.
- R6: `spi_dc` is 1 in every cycle in which `spi_valid` is 1.
- R7: While `spi_valid` is 1 and `spi_ready` is 0, `spi_valid` stays 1 and `spi_byte` holds its value in the next cycle.
- R8: A pixel is accepted on a clock edge where `pix_valid` and `pix_ready` are both 1. `pix_ready` is 0 from the cycle after acceptance until the final byte of that pixel has been taken, and it is 1 in the cycle that follows.
- R9: `frame_len` is captured at the first pixel of a frame; a value of 0 acts as 1. `frame_end` is a one-cycle pulse in the cycle right after the final byte of the frame's last pixel is taken, and it is 0 after every other pixel.
- R10: `fmt_sel` is captured at the first pixel of each frame. Changes to `fmt_sel` or `frame_len` while a frame is partly sent have no effect on that frame's bytes or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Block can take a pixel |
| pix_rgb | input | 24 | Pixel: red 23:16, green 15:8, blue 7:0 |
| fmt_sel | input | 1 | 0 = 16-bit packing, 1 = 18-bit packing |
| frame_len | input | LEN_W | Pixels per frame (0 treated as 1) |
| spi_valid | output | 1 | Byte available for the SPI transmitter |
| spi_ready | input | 1 | SPI transmitter takes the byte |
| spi_byte | output | 8 | Byte to transmit |
| spi_dc | output | 1 | Data/command select, 1 = data |
| frame_end | output | 1 | One-cycle pulse after the last byte of a frame |

## Verification
The bench sweeps every 8-bit value through each channel in both formats. A packer with a shifted field boundary or swapped byte order gives wrong bytes for some of these values, and so does one that keeps the low channel bits. Backpressure is stalled for a varying number of cycles on every byte position. A design that advances or drops a byte during a stall, or that takes a new pixel before the last byte leaves, shows up as a wrong or missing byte. The format and length are changed mid-frame, and frame lengths of 0 and 1 are exercised. A design that reads these inputs live, or that mistimes the end-of-frame pulse, produces the wrong byte count or a pulse on the wrong pixel.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

    localparam int MAX_BYTES = 3;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef enum logic {
        FMT_565 = 1'b0,
        FMT_666 = 1'b1
    } pxfmt_e;

    // bytes[0] leaves first
    typedef struct packed {
        logic [MAX_BYTES-1:0][7:0] bytes;
        logic [1:0]                count;
    } burst_t;

    function automatic logic [15:0] pack565(rgb_t p);
        return {p.r[7:3], p.g[7:2], p.b[7:3]};
    endfunction

    function automatic logic [7:0] trunc666(logic [7:0] c);
        return {c[7:2], 2'b00};
    endfunction

endpackage

// File: rtl/pxser_packer.sv
module pxser_packer
    import pxser_pkg::*;
(
    input  rgb_t   pix,
    input  pxfmt_e fmt,
    output burst_t burst
);
    logic [15:0]               word565;
    logic [MAX_BYTES-1:0][7:0] chan;

    assign chan[0] = pix.r;
    assign chan[1] = pix.g;
    assign chan[2] = pix.b;
    assign word565 = pack565(pix);

    always_comb begin
        burst = '0;
        if (fmt == FMT_565) begin
            burst.bytes[0] = word565[15:8];
            burst.bytes[1] = word565[7:0];
            burst.count    = 2'd2;
        end else begin
            for (int i = 0; i < MAX_BYTES; i++)
                burst.bytes[i] = trunc666(chan[i]);
            burst.count = 2'd3;
        end
    end
endmodule

// File: rtl/pxser_frame.sv
module pxser_frame
    import pxser_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  pxfmt_e           fmt_sel,
    input  logic [LEN_W-1:0] frame_len,
    output pxfmt_e           fmt_eff,
    output logic             last_pix
);
    localparam int CW = LEN_W + 1;

    logic [LEN_W-1:0] cnt_q, len_q, len_eff;
    pxfmt_e           fmt_q;
    logic             start;
    logic [CW-1:0]    nxt;

    assign start    = (cnt_q == '0);
    assign len_eff  = start ? frame_len : len_q;
    assign fmt_eff  = start ? fmt_sel : fmt_q;
    assign nxt      = {1'b0, cnt_q} + CW'(1);
    assign last_pix = (nxt >= {1'b0, len_eff});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= '0;
            fmt_q <= FMT_565;
        end else if (accept) begin
            if (start) begin
                fmt_q <= fmt_sel;
                len_q <= frame_len;
            end
            cnt_q <= last_pix ? '0 : nxt[LEN_W-1:0];
        end
    end

    // R10
    fmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> $stable(fmt_q));

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> (cnt_q < len_q));
endmodule

// File: rtl/pxser_byteseq.sv
module pxser_byteseq
    import pxser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  burst_t     burst_in,
    input  logic       last_in,
    input  logic       spi_ready,
    output logic       busy,
    output logic [7:0] spi_byte,
    output logic       frame_end
);
    burst_t     burst_q;
    logic [1:0] idx_q;
    logic       busy_q, last_q, eof_q;
    logic       take, final_byte;

    assign take       = busy_q && spi_ready;
    assign final_byte = take && (idx_q == burst_q.count - 2'd1);
    assign busy       = busy_q;
    assign spi_byte   = burst_q.bytes[idx_q];
    assign frame_end  = eof_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_q <= '0;
            idx_q   <= '0;
            busy_q  <= 1'b0;
            last_q  <= 1'b0;
            eof_q   <= 1'b0;
        end else begin
            eof_q <= final_byte && last_q;
            if (load) begin
                burst_q <= burst_in;
                idx_q   <= '0;
                busy_q  <= 1'b1;
                last_q  <= last_in;
            end else if (take) begin
                if (final_byte) busy_q <= 1'b0;
                else            idx_q  <= idx_q + 2'd1;
            end
        end
    end

    // R7
    hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !spi_ready) |=> (busy_q && $stable(spi_byte)));

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q < burst_q.count));

    // R9
    eof_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        eof_q |-> $past(busy_q && spi_ready));

    // R9
    eof_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eof_q |=> !eof_q);
endmodule

// File: rtl/pxser_top.sv
module pxser_top
    import pxser_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [23:0]      pix_rgb,
    input  logic             fmt_sel,
    input  logic [LEN_W-1:0] frame_len,
    output logic             spi_valid,
    input  logic             spi_ready,
    output logic [7:0]       spi_byte,
    output logic             spi_dc,
    output logic             frame_end
);
    logic   accept, busy, last_pix;
    pxfmt_e fmt_eff;
    burst_t burst;

    assign pix_ready = !busy;
    assign accept    = pix_valid && pix_ready;
    assign spi_valid = busy;
    assign spi_dc    = 1'b1;

    pxser_frame #(.LEN_W(LEN_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .fmt_sel   (pxfmt_e'(fmt_sel)),
        .frame_len (frame_len),
        .fmt_eff   (fmt_eff),
        .last_pix  (last_pix)
    );

    pxser_packer u_packer (
        .pix   (rgb_t'(pix_rgb)),
        .fmt   (fmt_eff),
        .burst (burst)
    );

    pxser_byteseq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .burst_in  (burst),
        .last_in   (last_pix),
        .spi_ready (spi_ready),
        .busy      (busy),
        .spi_byte  (spi_byte),
        .frame_end (frame_end)
    );

    // R8
    start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_valid) |-> $past(pix_valid && pix_ready));
endmodule

// File: tb/pxser_top_test.sv
module pxser_top_test;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pix_valid = 1'b0;
    logic             pix_ready;
    logic [23:0]      pix_rgb = '0;
    logic             fmt_sel = 1'b0;
    logic [LEN_W-1:0] frame_len = 16'd4;
    logic             spi_valid;
    logic             spi_ready = 1'b0;
    logic [7:0]       spi_byte;
    logic             spi_dc;
    logic             frame_end;

    int vectors = 0;
    int fails   = 0;
    int pos     = 0;
    int flen_m  = 1;
    int fmt_m   = 0;
    int pixn    = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    pxser_top #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_rgb(pix_rgb), .fmt_sel(fmt_sel), .frame_len(frame_len),
        .spi_valid(spi_valid), .spi_ready(spi_ready), .spi_byte(spi_byte),
        .spi_dc(spi_dc), .frame_end(frame_end)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (pixel %0d)", req, act, exp, pixn);
        end
    endtask

    // sends one pixel and consumes its bytes with varying stalls
    task automatic push(input int r, input int g, input int b);
        int nb, last, word;
        int exp [3];
        if (pos == 0) begin
            fmt_m  = fmt_sel;
            flen_m = (frame_len == 0) ? 1 : int'(frame_len);
        end
        last = (pos + 1 == flen_m);
        pos  = last ? 0 : pos + 1;
        if (fmt_m == 0) begin
            word   = (r / 8) * 2048 + (g / 4) * 32 + (b / 8);
            exp[0] = word / 256;
            exp[1] = word % 256;
            exp[2] = 0;
            nb     = 2;
        end else begin
            exp[0] = (r / 4) * 4;
            exp[1] = (g / 4) * 4;
            exp[2] = (b / 4) * 4;
            nb     = 3;
        end
        chk("R8 ready before pixel", int'(pix_ready), 1);
        pix_rgb   = 24'(r * 65536 + g * 256 + b);
        pix_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
        chk("R9 pulse width", int'(frame_end), 0);
        for (int i = 0; i < nb; i++) begin
            int stall;
            stall = (pixn * 5 + i * 3) % 4;
            for (int s = 0; s < stall; s++) begin
                chk("R7 valid held", int'(spi_valid), 1);
                chk(fmt_m == 0 ? "R3 byte (stall)" : "R5 byte (stall)", int'(spi_byte), exp[i]);
                chk("R8 ready low while busy", int'(pix_ready), 0);
                chk("R6 dc", int'(spi_dc), 1);
                @(negedge clk);
            end
            chk(fmt_m == 0 ? "R2 valid" : "R4 valid", int'(spi_valid), 1);
            chk(fmt_m == 0 ? "R3 byte" : "R5 byte", int'(spi_byte), exp[i]);
            chk("R6 dc", int'(spi_dc), 1);
            chk("R8 ready low while busy", int'(pix_ready), 0);
            spi_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            spi_ready = 1'b0;
        end
        chk(fmt_m == 0 ? "R2 byte count" : "R4 byte count", int'(spi_valid), 0);
        chk("R8 ready after last byte", int'(pix_ready), 1);
        chk("R9 frame_end", int'(frame_end), last);
        pixn++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 spi_valid in reset", int'(spi_valid), 0);
        chk("R1 pix_ready in reset", int'(pix_ready), 1);
        chk("R1 frame_end in reset", int'(frame_end), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 spi_valid after reset", int'(spi_valid), 0);
        chk("R1 pix_ready after reset", int'(pix_ready), 1);
        chk("R1 frame_end after reset", int'(frame_end), 0);

        // R2 R3: 16-bit sweep
        fmt_sel = 1'b0; frame_len = 16'd4;
        for (int v = 0; v < 256; v++) push(v, (v * 3 + 17) % 256, 255 - v);
        // R4 R5: 18-bit sweep
        fmt_sel = 1'b1;
        for (int v = 0; v < 256; v++) push((v * 7 + 5) % 256, v, (v * 11) % 256);
        // R10: format and length change mid-frame
        for (int k = 0; k < 60; k++) begin
            fmt_sel   = k[0];
            frame_len = 16'((k % 3) + 3);
            push((k * 37) % 256, (k * 91) % 256, (k * 53) % 256);
        end
        // R9: length 0 and 1 end every pixel; drain to frame start first
        while (pos != 0) push(1, 2, 3);
        frame_len = 16'd0;
        for (int k = 0; k < 8; k++) begin fmt_sel = k[1]; push(255 - k, k, 128 + k); end
        frame_len = 16'd1;
        for (int k = 0; k < 8; k++) begin fmt_sel = k[0]; push(k * 30, 255, k * 5); end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule